// File: doc/BRIEF.md
# Indirect CSR Window Router

This block sits beside a hart's CSR file and serves the indirect register window. It keeps three index registers, one each for machine, supervisor and virtual-supervisor level. A CSR read-modify-write is presented as a one-cycle `csr_valid` pulse with the CSR number, write data and write mask. An access to an index CSR updates the legal bits of that level's index register and returns the previous value. An access to a data-window CSR uses the current index of that level to pick a destination. Indexes in the priority range go to a local priority-array port, which answers in the same cycle. Indexes in the interrupt-file range go to an external interrupt-file port, which answers with a valid/error response after any number of cycles.

When virtualization is active, the supervisor index and window numbers are redirected to the virtual-supervisor copies. A window access that cannot be served ends with a fault strobe. The strobe carries a cause code that separates a virtual-instruction fault from an illegal-instruction fault.

Control is a three-state machine:
- `ST_IDLE` accepts a request. It moves to `ST_FILE_WAIT` for an interrupt-file access and to `ST_RESPOND` for every other case.
- `ST_FILE_WAIT` holds the file request until `file_rsp_valid` arrives, then moves to `ST_RESPOND`.
- `ST_RESPOND` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `csr_window_router`

## Requirements
- R1: After reset all three index registers read as zero, and `done` and `fault_strobe` are low.
- R2: A write to an index CSR changes only the bits set in both `csr_wmask` and the legal mask 0xFFF, giving new = (old & ~m) | (wdata & m). The response `rd_data` is the value before the write. CSR numbers: machine index 0x350, supervisor index 0x150, virtual-supervisor index 0x250.
- R3: An index write whose mask has no legal bit set leaves the register unchanged.
- R4: While `virt_on` is high, CSR 0x150 acts on the virtual-supervisor index and CSR 0x151 acts on the virtual-supervisor window. The machine and supervisor registers are not affected. With `virt_on` low the numbers are used as given.
- R5: A window access (machine 0x351, supervisor 0x151, virtual-supervisor 0x251) whose index is in 0x30..0x3F goes to the priority port at machine or supervisor level, and `rd_data` is `prio_rdata`. `prio_level` is 0 for machine and 1 for supervisor. With XLEN 64, an odd index in this range fails.
- R6: A virtual-supervisor window access whose index is in the priority range always fails.
- R7: An index in 0x70..0xFF goes to the interrupt-file port only if a file is present for that level. Machine level uses `file_present_m`; supervisor and virtual-supervisor levels use `file_present_s`. If no file is present, the access fails.
- R8: A virtual-supervisor file access also needs `guest_sel` to be nonzero and no larger than `guest_count`; otherwise it fails.
- R9: A window access whose index is outside both ranges fails.
- R10: A failed access gives a one-cycle `fault_strobe` together with `done`. The cause is 2'b10 (virtual instruction) when `virt_on` is high and the window is the virtual-supervisor one, and 2'b01 (illegal instruction) in every other case. `rd_data` is zero on a fault.
- R11: A file request carries:
  - the index;
  - the level (0 machine, 1 supervisor);
  - a virtual flag;
  - the guest number (zero when the window is not the virtual-supervisor one);
  - an XLEN code (2 for 64, 1 for 32).

  The request stays steady until `file_rsp_valid`. The response data becomes `rd_data`, and an error response becomes a fault classified as in R10.
- R12: A CSR number that is none of the six window numbers raises an illegal-instruction fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_valid | input | 1 | One-cycle access request |
| csr_num | input | 12 | CSR number |
| csr_wdata | input | XLEN | Write data |
| csr_wmask | input | XLEN | Write mask |
| virt_on | input | 1 | Virtualization active |
| guest_sel | input | GUEST_W | Selected guest interrupt file |
| guest_count | input | GUEST_W | Number of guest files implemented |
| file_present_m | input | 1 | Machine-level interrupt file present |
| file_present_s | input | 1 | Supervisor-level interrupt file present |
| done | output | 1 | Access complete strobe |
| rd_data | output | XLEN | Read result |
| fault_strobe | output | 1 | Access failed |
| fault_cause | output | 2 | 01 illegal, 10 virtual instruction |
| prio_req | output | 1 | Priority-array access |
| prio_we | output | 1 | Priority write (mask nonzero) |
| prio_level | output | 1 | 0 machine, 1 supervisor |
| prio_index | output | SEL_W | Priority register index |
| prio_wdata | output | XLEN | Priority write data |
| prio_wmask | output | XLEN | Priority write mask |
| prio_rdata | input | XLEN | Priority read data, same cycle |
| file_req_valid | output | 1 | Interrupt-file request |
| file_req_index | output | SEL_W | File register index |
| file_req_level | output | 1 | 0 machine, 1 supervisor |
| file_req_virt | output | 1 | Virtual-supervisor window |
| file_req_guest | output | GUEST_W | Guest file number |
| file_req_xlen | output | 2 | XLEN code |
| file_req_wdata | output | XLEN | File write data |
| file_req_wmask | output | XLEN | File write mask |
| file_rsp_valid | input | 1 | File response strobe |
| file_rsp_rdata | input | XLEN | File response data |
| file_rsp_err | input | 1 | File response error |

## Verification
The assertions assume that `csr_valid` is pulsed only while the block is idle. They also assume that `guest_count` is held steady while a file request is outstanding, and that `file_rsp_valid` is raised only while a file request is pending. The bench's access task meets all three. It issues one pulse, waits for `done`, and lets one more edge pass before the next access. It changes the virtualization and guest inputs only between accesses. Its file responder answers only an open request and drops its strobe after one cycle.

// File: rtl/win_pkg.sv
package win_pkg;

    localparam logic [11:0] CSR_M_SEL  = 12'h350;
    localparam logic [11:0] CSR_M_WIN  = 12'h351;
    localparam logic [11:0] CSR_S_SEL  = 12'h150;
    localparam logic [11:0] CSR_S_WIN  = 12'h151;
    localparam logic [11:0] CSR_VS_SEL = 12'h250;
    localparam logic [11:0] CSR_VS_WIN = 12'h251;

    localparam int NUM_LVL = 3;

    typedef enum logic [1:0] {
        LVL_M  = 2'd0,
        LVL_S  = 2'd1,
        LVL_VS = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SEL  = 2'd1,
        ACC_WIN  = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        RT_FAIL = 2'd0,
        RT_PRIO = 2'd1,
        RT_FILE = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FILE_WAIT = 2'd1,
        ST_RESPOND   = 2'd2
    } state_e;

    localparam logic [1:0] CAUSE_NONE    = 2'b00;
    localparam logic [1:0] CAUSE_ILLEGAL = 2'b01;
    localparam logic [1:0] CAUSE_VIRTUAL = 2'b10;

endpackage

// File: rtl/win_decode.sv
module win_decode
    import win_pkg::*;
#(
    parameter int          SEL_W   = 12,
    parameter int          GUEST_W = 6,
    parameter int          XLEN    = 64,
    parameter logic [11:0] PRIO_LO = 12'h030,
    parameter logic [11:0] PRIO_HI = 12'h03F,
    parameter logic [11:0] FILE_LO = 12'h070,
    parameter logic [11:0] FILE_HI = 12'h0FF
) (
    input  logic [11:0]              csr_num,
    input  logic                     virt_on,
    input  logic [NUM_LVL*SEL_W-1:0] sel_flat,
    input  logic                     file_present_m,
    input  logic                     file_present_s,
    input  logic [GUEST_W-1:0]       guest_sel,
    input  logic [GUEST_W-1:0]       guest_count,
    output acc_e                     acc,
    output lvl_e                     lvl,
    output logic [SEL_W-1:0]         index,
    output route_e                   route
);

    localparam logic ODD_FAILS = (XLEN == 64);

    logic [11:0] num_x;
    logic        in_prio;
    logic        in_file;
    logic        has_file;
    logic        guest_ok;

    // Redirect supervisor window numbers while virtualized.
    always_comb begin
        num_x = csr_num;
        if (virt_on) begin
            if (csr_num == CSR_S_SEL) begin
                num_x = CSR_VS_SEL;
            end else if (csr_num == CSR_S_WIN) begin
                num_x = CSR_VS_WIN;
            end
        end
    end

    always_comb begin
        acc = ACC_NONE;
        lvl = LVL_M;
        unique case (num_x)
            CSR_M_SEL:  begin acc = ACC_SEL; lvl = LVL_M;  end
            CSR_M_WIN:  begin acc = ACC_WIN; lvl = LVL_M;  end
            CSR_S_SEL:  begin acc = ACC_SEL; lvl = LVL_S;  end
            CSR_S_WIN:  begin acc = ACC_WIN; lvl = LVL_S;  end
            CSR_VS_SEL: begin acc = ACC_SEL; lvl = LVL_VS; end
            CSR_VS_WIN: begin acc = ACC_WIN; lvl = LVL_VS; end
            default:    begin acc = ACC_NONE; lvl = LVL_M; end
        endcase
    end

    always_comb begin
        unique case (lvl)
            LVL_S:   index = sel_flat[1*SEL_W +: SEL_W];
            LVL_VS:  index = sel_flat[2*SEL_W +: SEL_W];
            default: index = sel_flat[0 +: SEL_W];
        endcase
    end

    assign in_prio  = (index >= SEL_W'(PRIO_LO)) && (index <= SEL_W'(PRIO_HI));
    assign in_file  = (index >= SEL_W'(FILE_LO)) && (index <= SEL_W'(FILE_HI));
    assign has_file = (lvl == LVL_M) ? file_present_m : file_present_s;
    assign guest_ok = (lvl != LVL_VS) ||
                      ((guest_sel != '0) && (guest_sel <= guest_count));

    always_comb begin
        route = RT_FAIL;
        if (in_prio) begin
            if ((lvl != LVL_VS) && !(ODD_FAILS && index[0])) begin
                route = RT_PRIO;
            end
        end else if (in_file) begin
            if (has_file && guest_ok) begin
                route = RT_FILE;
            end
        end
    end

endmodule

// File: rtl/win_select_regs.sv
module win_select_regs
    import win_pkg::*;
#(
    parameter int               SEL_W    = 12,
    parameter logic [SEL_W-1:0] SEL_MASK = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_lvl,
    input  logic [SEL_W-1:0]         wdata,
    input  logic [SEL_W-1:0]         wmask,
    output logic [NUM_LVL*SEL_W-1:0] sel_flat
);

    logic [SEL_W-1:0] eff_mask;
    assign eff_mask = wmask & SEL_MASK;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        logic [SEL_W-1:0] reg_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q <= '0;
            end else if (wr_en && (wr_lvl == 2'(g)) && (|eff_mask)) begin
                reg_q <= (reg_q & ~eff_mask) | (wdata & eff_mask);
            end
        end

        assign sel_flat[g*SEL_W +: SEL_W] = reg_q;
    end

endmodule

// File: rtl/win_ctrl.sv
module win_ctrl
    import win_pkg::*;
#(
    parameter int SEL_W   = 12,
    parameter int GUEST_W = 6,
    parameter int XLEN    = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_valid,
    input  acc_e               acc,
    input  lvl_e               lvl,
    input  route_e             route,
    input  logic [SEL_W-1:0]   index,
    input  logic               virt_on,
    input  logic [GUEST_W-1:0] guest_sel,
    input  logic [XLEN-1:0]    csr_wdata,
    input  logic [XLEN-1:0]    csr_wmask,
    input  logic [XLEN-1:0]    prio_rdata,
    input  logic               file_rsp_valid,
    input  logic [XLEN-1:0]    file_rsp_rdata,
    input  logic               file_rsp_err,
    output logic               sel_wr_en,
    output logic               prio_req,
    output logic               prio_we,
    output logic               file_req_valid,
    output logic [SEL_W-1:0]   file_req_index,
    output logic               file_req_level,
    output logic               file_req_virt,
    output logic [GUEST_W-1:0] file_req_guest,
    output logic [1:0]         file_req_xlen,
    output logic [XLEN-1:0]    file_req_wdata,
    output logic [XLEN-1:0]    file_req_wmask,
    output logic               done,
    output logic [XLEN-1:0]    rd_data,
    output logic               fault_strobe,
    output logic [1:0]         fault_cause
);

    localparam logic [1:0] XLEN_CODE = (XLEN == 64) ? 2'd2 : 2'd1;

    state_e state_q, state_d;

    logic               accept;
    logic               fail_now;
    logic               vfault_now;
    logic [XLEN-1:0]    rdata_q;
    logic               fault_q;
    logic [1:0]         cause_q;
    logic               vfault_q;
    logic [SEL_W-1:0]   idx_q;
    logic               lvl_s_q;
    logic               virt_q;
    logic [GUEST_W-1:0] guest_q;
    logic [XLEN-1:0]    wdata_q;
    logic [XLEN-1:0]    wmask_q;

    assign accept     = (state_q == ST_IDLE) && csr_valid;
    assign vfault_now = virt_on && (lvl == LVL_VS);
    assign fail_now   = (acc == ACC_NONE) || ((acc == ACC_WIN) && (route == RT_FAIL));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (csr_valid) begin
                    state_d = ((acc == ACC_WIN) && (route == RT_FILE)) ? ST_FILE_WAIT : ST_RESPOND;
                end
            end
            ST_FILE_WAIT: begin
                if (file_rsp_valid) begin
                    state_d = ST_RESPOND;
                end
            end
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Result capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            fault_q  <= 1'b0;
            cause_q  <= CAUSE_NONE;
            vfault_q <= 1'b0;
            idx_q    <= '0;
            lvl_s_q  <= 1'b0;
            virt_q   <= 1'b0;
            guest_q  <= '0;
            wdata_q  <= '0;
            wmask_q  <= '0;
        end else if (accept) begin
            vfault_q <= vfault_now;
            idx_q    <= index;
            lvl_s_q  <= (lvl != LVL_M);
            virt_q   <= (lvl == LVL_VS);
            guest_q  <= (lvl == LVL_VS) ? guest_sel : '0;
            wdata_q  <= csr_wdata;
            wmask_q  <= csr_wmask;
            fault_q  <= fail_now;
            if (fail_now) begin
                rdata_q <= '0;
                cause_q <= ((acc == ACC_WIN) && vfault_now) ? CAUSE_VIRTUAL : CAUSE_ILLEGAL;
            end else begin
                cause_q <= CAUSE_NONE;
                if (acc == ACC_SEL) begin
                    rdata_q <= XLEN'(index);
                end else if (route == RT_PRIO) begin
                    rdata_q <= prio_rdata;
                end else begin
                    rdata_q <= '0;
                end
            end
        end else if ((state_q == ST_FILE_WAIT) && file_rsp_valid) begin
            fault_q <= file_rsp_err;
            rdata_q <= file_rsp_err ? '0 : file_rsp_rdata;
            if (file_rsp_err) begin
                cause_q <= vfault_q ? CAUSE_VIRTUAL : CAUSE_ILLEGAL;
            end else begin
                cause_q <= CAUSE_NONE;
            end
        end
    end

    // Outputs.
    always_comb begin
        sel_wr_en      = accept && (acc == ACC_SEL);
        prio_req       = accept && (acc == ACC_WIN) && (route == RT_PRIO);
        prio_we        = prio_req && (|csr_wmask);
        file_req_valid = (state_q == ST_FILE_WAIT);
        file_req_index = idx_q;
        file_req_level = lvl_s_q;
        file_req_virt  = virt_q;
        file_req_guest = guest_q;
        file_req_xlen  = XLEN_CODE;
        file_req_wdata = wdata_q;
        file_req_wmask = wmask_q;
        done           = (state_q == ST_RESPOND);
        rd_data        = rdata_q;
        fault_strobe   = done && fault_q;
        fault_cause    = fault_strobe ? cause_q : CAUSE_NONE;
    end

endmodule

// File: rtl/csr_window_router.sv
module csr_window_router
    import win_pkg::*;
#(
    parameter int          XLEN     = 64,
    parameter int          SEL_W    = 12,
    parameter int          GUEST_W  = 6,
    parameter logic [11:0] SEL_MASK = 12'hFFF,
    parameter logic [11:0] PRIO_LO  = 12'h030,
    parameter logic [11:0] PRIO_HI  = 12'h03F,
    parameter logic [11:0] FILE_LO  = 12'h070,
    parameter logic [11:0] FILE_HI  = 12'h0FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_valid,
    input  logic [11:0]        csr_num,
    input  logic [XLEN-1:0]    csr_wdata,
    input  logic [XLEN-1:0]    csr_wmask,
    input  logic               virt_on,
    input  logic [GUEST_W-1:0] guest_sel,
    input  logic [GUEST_W-1:0] guest_count,
    input  logic               file_present_m,
    input  logic               file_present_s,
    output logic               done,
    output logic [XLEN-1:0]    rd_data,
    output logic               fault_strobe,
    output logic [1:0]         fault_cause,
    output logic               prio_req,
    output logic               prio_we,
    output logic               prio_level,
    output logic [SEL_W-1:0]   prio_index,
    output logic [XLEN-1:0]    prio_wdata,
    output logic [XLEN-1:0]    prio_wmask,
    input  logic [XLEN-1:0]    prio_rdata,
    output logic               file_req_valid,
    output logic [SEL_W-1:0]   file_req_index,
    output logic               file_req_level,
    output logic               file_req_virt,
    output logic [GUEST_W-1:0] file_req_guest,
    output logic [1:0]         file_req_xlen,
    output logic [XLEN-1:0]    file_req_wdata,
    output logic [XLEN-1:0]    file_req_wmask,
    input  logic               file_rsp_valid,
    input  logic [XLEN-1:0]    file_rsp_rdata,
    input  logic               file_rsp_err
);

    logic [NUM_LVL*SEL_W-1:0] sel_flat;
    acc_e                     acc;
    lvl_e                     lvl;
    route_e                   route;
    logic [SEL_W-1:0]         index;
    logic                     sel_wr_en;

    win_decode #(
        .SEL_W  (SEL_W),
        .GUEST_W(GUEST_W),
        .XLEN   (XLEN),
        .PRIO_LO(PRIO_LO),
        .PRIO_HI(PRIO_HI),
        .FILE_LO(FILE_LO),
        .FILE_HI(FILE_HI)
    ) u_decode (
        .csr_num       (csr_num),
        .virt_on       (virt_on),
        .sel_flat      (sel_flat),
        .file_present_m(file_present_m),
        .file_present_s(file_present_s),
        .guest_sel     (guest_sel),
        .guest_count   (guest_count),
        .acc           (acc),
        .lvl           (lvl),
        .index         (index),
        .route         (route)
    );

    win_select_regs #(
        .SEL_W   (SEL_W),
        .SEL_MASK(SEL_W'(SEL_MASK))
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_wr_en),
        .wr_lvl  (lvl),
        .wdata   (csr_wdata[SEL_W-1:0]),
        .wmask   (csr_wmask[SEL_W-1:0]),
        .sel_flat(sel_flat)
    );

    win_ctrl #(
        .SEL_W  (SEL_W),
        .GUEST_W(GUEST_W),
        .XLEN   (XLEN)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .csr_valid     (csr_valid),
        .acc           (acc),
        .lvl           (lvl),
        .route         (route),
        .index         (index),
        .virt_on       (virt_on),
        .guest_sel     (guest_sel),
        .csr_wdata     (csr_wdata),
        .csr_wmask     (csr_wmask),
        .prio_rdata    (prio_rdata),
        .file_rsp_valid(file_rsp_valid),
        .file_rsp_rdata(file_rsp_rdata),
        .file_rsp_err  (file_rsp_err),
        .sel_wr_en     (sel_wr_en),
        .prio_req      (prio_req),
        .prio_we       (prio_we),
        .file_req_valid(file_req_valid),
        .file_req_index(file_req_index),
        .file_req_level(file_req_level),
        .file_req_virt (file_req_virt),
        .file_req_guest(file_req_guest),
        .file_req_xlen (file_req_xlen),
        .file_req_wdata(file_req_wdata),
        .file_req_wmask(file_req_wmask),
        .done          (done),
        .rd_data       (rd_data),
        .fault_strobe  (fault_strobe),
        .fault_cause   (fault_cause)
    );

    assign prio_level = (lvl == LVL_S);
    assign prio_index = index;
    assign prio_wdata = csr_wdata;
    assign prio_wmask = csr_wmask;

endmodule

// File: rtl/win_router_chk.sv
module win_router_chk #(
    parameter int          XLEN    = 64,
    parameter int          SEL_W   = 12,
    parameter int          GUEST_W = 6,
    parameter logic [11:0] PRIO_LO = 12'h030,
    parameter logic [11:0] PRIO_HI = 12'h03F
) (
    input logic               clk,
    input logic               rst_n,
    input logic               csr_valid,
    input logic [11:0]        csr_num,
    input logic [GUEST_W-1:0] guest_count,
    input logic               done,
    input logic               fault_strobe,
    input logic [1:0]         fault_cause,
    input logic               prio_req,
    input logic [SEL_W-1:0]   prio_index,
    input logic               file_req_valid,
    input logic [SEL_W-1:0]   file_req_index,
    input logic               file_req_virt,
    input logic [GUEST_W-1:0] file_req_guest,
    input logic               file_rsp_valid
);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_strobe |-> done);

    // R10
    cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_strobe |-> (fault_cause == 2'b01 || fault_cause == 2'b10));

    // R11
    file_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (file_req_valid && !file_rsp_valid) |=>
            (file_req_valid && $stable(file_req_index) && $stable(file_req_guest)));

    // R5
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prio_req && (file_req_valid || done)));

    // R5
    prio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prio_req |-> (csr_valid && prio_index >= SEL_W'(PRIO_LO) && prio_index <= SEL_W'(PRIO_HI)
                      && (XLEN != 64 || !prio_index[0])));

    // R6
    vs_no_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prio_req |-> (csr_num != 12'h251));

    // R8
    guest_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (file_req_valid && file_req_virt) |->
            (file_req_guest != '0 && file_req_guest <= guest_count));

endmodule

bind csr_window_router win_router_chk #(
    .XLEN   (XLEN),
    .SEL_W  (SEL_W),
    .GUEST_W(GUEST_W),
    .PRIO_LO(PRIO_LO),
    .PRIO_HI(PRIO_HI)
) u_chk (.*);

// File: tb/tb_csr_window_router.sv
`timescale 1ns/1ps
module tb_csr_window_router;

    localparam int XLEN    = 64;
    localparam int SEL_W   = 12;
    localparam int GUEST_W = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               csr_valid = 1'b0;
    logic [11:0]        csr_num = '0;
    logic [XLEN-1:0]    csr_wdata = '0;
    logic [XLEN-1:0]    csr_wmask = '0;
    logic               virt_on = 1'b0;
    logic [GUEST_W-1:0] guest_sel = '0;
    logic [GUEST_W-1:0] guest_count = '0;
    logic               file_present_m = 1'b0;
    logic               file_present_s = 1'b0;
    logic               done;
    logic [XLEN-1:0]    rd_data;
    logic               fault_strobe;
    logic [1:0]         fault_cause;
    logic               prio_req, prio_we, prio_level;
    logic [SEL_W-1:0]   prio_index;
    logic [XLEN-1:0]    prio_wdata, prio_wmask, prio_rdata;
    logic               file_req_valid, file_req_level, file_req_virt;
    logic [SEL_W-1:0]   file_req_index;
    logic [GUEST_W-1:0] file_req_guest;
    logic [1:0]         file_req_xlen;
    logic [XLEN-1:0]    file_req_wdata, file_req_wmask;
    logic               file_rsp_valid = 1'b0;
    logic [XLEN-1:0]    file_rsp_rdata = '0;
    logic               file_rsp_err = 1'b0;

    int checks = 0;
    int errors = 0;
    logic tb_file_err = 1'b0;
    int   rsp_cnt = 0;

    always #2.5 clk = ~clk;

    csr_window_router dut (.*);

    // Priority-array model: same-cycle data derived from the request.
    assign prio_rdata = 64'hA500_0000_0000_0000 | (64'(prio_level) << 16) | 64'(prio_index);

    // Interrupt-file model: answers two edges after a request appears.
    always @(posedge clk) begin
        if (file_rsp_valid) begin
            file_rsp_valid <= 1'b0;
            file_rsp_err   <= 1'b0;
        end else if (file_req_valid) begin
            if (rsp_cnt == 1) begin
                rsp_cnt        <= 0;
                file_rsp_valid <= 1'b1;
                file_rsp_err   <= tb_file_err;
                file_rsp_rdata <= 64'hF11E_0000_0000_0000 | 64'(file_req_index);
            end else begin
                rsp_cnt <= rsp_cnt + 1;
            end
        end
    end

    // Results of the last access.
    logic [XLEN-1:0]    r_data;
    logic               r_fault;
    logic [1:0]         r_cause;
    logic               p_seen, p_level;
    logic [SEL_W-1:0]   p_index;
    logic               f_seen, f_level, f_virt;
    logic [SEL_W-1:0]   f_index;
    logic [GUEST_W-1:0] f_guest;
    logic [1:0]         f_xlen;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [11:0] num, input logic [63:0] wd, input logic [63:0] wm);
        @(negedge clk);
        csr_num   = num;
        csr_wdata = wd;
        csr_wmask = wm;
        csr_valid = 1'b1;
        #1;
        p_seen  = prio_req;
        p_level = prio_level;
        p_index = prio_index;
        f_seen  = 1'b0;
        @(posedge clk);
        #1 csr_valid = 1'b0;
        while (!done) begin
            if (file_req_valid) begin
                f_seen  = 1'b1;
                f_index = file_req_index;
                f_level = file_req_level;
                f_virt  = file_req_virt;
                f_guest = file_req_guest;
                f_xlen  = file_req_xlen;
            end
            @(negedge clk);
        end
        r_data  = rd_data;
        r_fault = fault_strobe;
        r_cause = fault_cause;
        @(posedge clk);
        #1;
        chk("R10 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 done low", 64'(done), 64'd0);
        chk("R1 fault low", 64'(fault_strobe), 64'd0);
        access(12'h350, 64'd0, 64'd0);
        chk("R1 m index zero", r_data, 64'd0);
        access(12'h150, 64'd0, 64'd0);
        chk("R1 s index zero", r_data, 64'd0);
        access(12'h250, 64'd0, 64'd0);
        chk("R1 vs index zero", r_data, 64'd0);
    endtask

    task automatic t_select;
        access(12'h350, 64'hFFFF_1234, '1);
        chk("R2 old value returned", r_data, 64'd0);
        access(12'h350, 64'd0, 64'd0);
        chk("R2 legal bits written", r_data, 64'h234);
        access(12'h350, 64'hFFFF, 64'hF000);
        access(12'h350, 64'd0, 64'd0);
        chk("R3 zero effective mask", r_data, 64'h234);
        access(12'h350, 64'hFFF, 64'h0F0);
        chk("R2 old before partial", r_data, 64'h234);
        access(12'h350, 64'd0, 64'd0);
        chk("R2 partial mask merge", r_data, 64'h2F4);
    endtask

    task automatic t_virt;
        virt_on = 1'b1;
        access(12'h150, 64'h77, '1);
        access(12'h250, 64'd0, 64'd0);
        chk("R4 redirected to vs index", r_data, 64'h77);
        virt_on = 1'b0;
        access(12'h150, 64'd0, 64'd0);
        chk("R4 s index untouched", r_data, 64'd0);
        access(12'h350, 64'd0, 64'd0);
        chk("R4 m index untouched", r_data, 64'h2F4);
    endtask

    task automatic t_prio;
        access(12'h350, 64'h30, '1);
        access(12'h351, 64'h55, 64'hFF);
        chk("R5 m prio request", 64'(p_seen), 64'd1);
        chk("R5 m prio level", 64'(p_level), 64'd0);
        chk("R5 m prio index", 64'(p_index), 64'h30);
        chk("R5 m prio data", r_data, 64'hA500_0000_0000_0030);
        chk("R5 m prio no fault", 64'(r_fault), 64'd0);
        access(12'h150, 64'h3E, '1);
        access(12'h151, 64'd0, 64'd0);
        chk("R5 s prio level", 64'(p_level), 64'd1);
        chk("R5 s prio data", r_data, 64'hA500_0000_0001_003E);
        access(12'h350, 64'h31, '1);
        access(12'h351, 64'd0, 64'd0);
        chk("R5 odd index no request", 64'(p_seen), 64'd0);
        chk("R5 odd index illegal", 64'(r_cause), 64'b01);
        chk("R10 fault data zero", r_data, 64'd0);
    endtask

    task automatic t_vs_prio;
        virt_on = 1'b1;
        access(12'h150, 64'h30, '1);
        access(12'h151, 64'd0, 64'd0);
        chk("R6 vs prio no request", 64'(p_seen), 64'd0);
        chk("R6 vs prio fault", 64'(r_fault), 64'd1);
        chk("R10 virtual cause", 64'(r_cause), 64'b10);
        virt_on = 1'b0;
        access(12'h251, 64'd0, 64'd0);
        chk("R10 vs window without virt illegal", 64'(r_cause), 64'b01);
    endtask

    task automatic t_file;
        file_present_m = 1'b1;
        access(12'h350, 64'h70, '1);
        access(12'h351, 64'h9, 64'h1);
        chk("R7 m file request", 64'(f_seen), 64'd1);
        chk("R11 file index", 64'(f_index), 64'h70);
        chk("R11 file level", 64'(f_level), 64'd0);
        chk("R11 file virt", 64'(f_virt), 64'd0);
        chk("R11 file guest", 64'(f_guest), 64'd0);
        chk("R11 file xlen", 64'(f_xlen), 64'd2);
        chk("R11 file data", r_data, 64'hF11E_0000_0000_0070);
        tb_file_err = 1'b1;
        access(12'h351, 64'd0, 64'd0);
        tb_file_err = 1'b0;
        chk("R11 error gives illegal", 64'(r_cause), 64'b01);
        file_present_m = 1'b0;
        access(12'h351, 64'd0, 64'd0);
        chk("R7 no file no request", 64'(f_seen), 64'd0);
        chk("R7 no file illegal", 64'(r_cause), 64'b01);
    endtask

    task automatic t_guest;
        file_present_s = 1'b1;
        guest_count    = 6'd3;
        virt_on        = 1'b1;
        access(12'h150, 64'hFF, '1);
        guest_sel = 6'd0;
        access(12'h151, 64'd0, 64'd0);
        chk("R8 guest zero fault", 64'(r_cause), 64'b10);
        guest_sel = 6'd4;
        access(12'h151, 64'd0, 64'd0);
        chk("R8 guest above count fault", 64'(r_cause), 64'b10);
        guest_sel = 6'd3;
        access(12'h151, 64'd0, 64'd0);
        chk("R8 guest at count served", 64'(r_fault), 64'd0);
        chk("R8 guest number sent", 64'(f_guest), 64'd3);
        chk("R11 vs file virt flag", 64'(f_virt), 64'd1);
        chk("R11 vs file level", 64'(f_level), 64'd1);
        tb_file_err = 1'b1;
        access(12'h151, 64'd0, 64'd0);
        tb_file_err = 1'b0;
        chk("R11 vs error virtual", 64'(r_cause), 64'b10);
        virt_on = 1'b0;
    endtask

    task automatic t_outside;
        access(12'h350, 64'h40, '1);
        access(12'h351, 64'd0, 64'd0);
        chk("R9 outside ranges fault", 64'(r_cause), 64'b01);
        chk("R9 outside no prio", 64'(p_seen), 64'd0);
        access(12'h300, 64'd0, 64'd0);
        chk("R12 unknown csr illegal", 64'(r_cause), 64'b01);
        virt_on = 1'b1;
        access(12'h344, 64'd0, 64'd0);
        chk("R12 unknown csr illegal virt", 64'(r_cause), 64'b01);
        virt_on = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_select();
        t_virt();
        t_prio();
        t_vs_prio();
        t_file();
        t_guest();
        t_outside();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule